// File: doc/BRIEF.md
# System Control Register File

A privileged register file for system configuration, reached by a host core through move-to and move-from coprocessor commands. Each command names a primary register index, a secondary index and two opcode fields (a high opcode and a low opcode). The block first decides whether the access is legal for that register. A legal write passes through the register's own keep mask and forced-one bits. A legal read returns the stored word. An illegal access changes nothing and is reported as refused.

Two logical banks of sixteen words exist, chosen by whether the low opcode is zero. Only words that carry state are built. The zero bank holds identity, control, translation base, domain, fault status, fault address, lock, process identifier and access-permission words. The nonzero bank holds a cache-type word and an auxiliary control word. Primary index 14 opens five separate debug words, picked by the secondary index. Primary indices 7, 8 and 10 are operation slots: they are accepted but keep nothing.

Top module: `sysctl_regfile`

## Requirements
- R1: A command issued while `userMode` is 1, or with a nonzero `op1`, is refused and changes no stored word.
- R2: Each command cycle gives exactly one response cycle on the next clock (`rspValid`=1). `rspRefused` is 0 for done and 1 for refused. `rdData` is zero for refused accesses and for writes, and `rspValid` is 0 after an idle cycle.
- R3: After reset the following values hold: primary 0 with `op2`=0 reads `ID_VALUE` (default 0x69052000); primary 0 with `op2`≠0 reads 0x0B1AA1AA; primary 1 with `op2`=0 reads 0x00000078; primary 1 with `op2`≠0 reads 0.
- R4: A write to primary 1 with `op2`=0 keeps data bits 13:11, 9:7 and 2:0. Bits 6:3 read as 1, and bits 31:14 and bit 10 read as 0.
- R5: With `op2`≠0, primary 1 is a separate word that keeps only data bits 5:4 and 1:0. It does not disturb the `op2`=0 word.
- R6: Zero-bank keep masks are: primary 2 bits 31:14; primaries 3 and 6 all bits; primary 5 bits 10:9 and 7:0; primary 9 bit 0; primary 13 bits 31:25; primary 15 bits 13:0.
- R7: Primary 14 with `op2`=0 holds five independent full-width words for `secIdx` 0, 3, 4, 8 and 9. Any other `secIdx`, or any nonzero `op2`, is refused.
- R8: Legal combinations are: primaries 0 and 1 need `secIdx`=0 with any `op2`; primaries 2, 3, 5, 6, 9 and 13 need `secIdx`=0 and `op2`=0; primary 15 needs `secIdx`=1 and `op2`=0. Primaries 4, 11 and 12 are always refused.
- R9: Writes to primary 0 in either bank complete as done and leave the read value unchanged.
- R10: Primaries 7, 8 and 10 accept any `secIdx` and `op2`, store nothing, and read as zero.
- R11: An active-low synchronous reset restores the R3 values, clears every other word and clears the response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | A command is present this cycle |
| cmdWrite | input | 1 | 1 = move to register file, 0 = move from |
| userMode | input | 1 | Core is running unprivileged |
| primIdx | input | 4 | Primary register index |
| secIdx | input | 4 | Secondary register index |
| op1 | input | 3 | High opcode field, must be zero |
| op2 | input | 3 | Low opcode field, picks the bank |
| wrData | input | 32 | Write data |
| rspValid | output | 1 | Response present (one cycle after command) |
| rspRefused | output | 1 | 0 = done, 1 = refused |
| rdData | output | 32 | Read result, zero unless a legal read |

## Verification
A wrong mask or forced bit stays hidden until the next legal read of that word. The bench therefore writes all-ones and all-zeros to each masked word and reads it back on the very next command. A bad legality decision shows up on the response one cycle after the command, while a stray write shows up at the next read of the word it hit. For that reason each refused write is followed at once by a read of its target. Cross-bank and cross-debug corruption is caught by reading every sibling word after the writes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW = 32;
  localparam int NSLOT = 17;
  localparam int SW = $clog2(NSLOT);
  localparam logic [DW-1:0] CTYPE_VALUE = 32'h0B1AA1AA;
  localparam logic [DW-1:0] CTRL_RESET  = 32'h00000078;

  // Storage slots: only words that carry state, plus one zero slot.
  typedef enum logic [SW-1:0] {
    SL_ID, SL_CTRL, SL_TTB, SL_DOM, SL_FSR, SL_FAR, SL_LOCK, SL_PID,
    SL_CPACC, SL_DBG0, SL_DBG3, SL_DBG4, SL_DBG8, SL_DBG9,
    SL_CTYPE, SL_AUX, SL_NONE
  } slot_e;

  typedef struct packed {
    logic  valid;
    logic  accept;
    logic  write;
    slot_e slot;
  } strobe_t;

  function automatic logic [DW-1:0] slotMask(slot_e s);
    case (s)
      SL_CTRL:  return 32'h00003B87;
      SL_TTB:   return 32'hFFFFC000;
      SL_DOM, SL_FAR, SL_DBG0, SL_DBG3, SL_DBG4, SL_DBG8, SL_DBG9:
                return 32'hFFFFFFFF;
      SL_FSR:   return 32'h000006FF;
      SL_LOCK:  return 32'h00000001;
      SL_PID:   return 32'hFE000000;
      SL_CPACC: return 32'h00003FFF;
      SL_AUX:   return 32'h00000033;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] slotForce(slot_e s);
    return (s == SL_CTRL) ? 32'h00000078 : '0;
  endfunction

  function automatic logic [DW-1:0] slotReset(slot_e s, logic [DW-1:0] idValue);
    case (s)
      SL_ID:    return idValue;
      SL_CTYPE: return CTYPE_VALUE;
      SL_CTRL:  return CTRL_RESET;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic       cmdValid,
  input  logic       cmdWrite,
  input  logic       userMode,
  input  logic [3:0] primIdx,
  input  logic [3:0] secIdx,
  input  logic [2:0] op1,
  input  logic [2:0] op2,
  output strobe_t    strb
);
  logic  legal;
  slot_e slot;
  logic  secZero, op2Zero, plainOk;

  assign secZero = (secIdx == 4'd0);
  assign op2Zero = (op2 == 3'd0);
  assign plainOk = secZero && op2Zero;

  always_comb begin
    legal = 1'b0;
    slot  = SL_NONE;
    if (!userMode && op1 == 3'd0) begin
      case (primIdx)
        4'd0:  begin legal = secZero; slot = op2Zero ? SL_ID   : SL_CTYPE; end
        4'd1:  begin legal = secZero; slot = op2Zero ? SL_CTRL : SL_AUX;   end
        4'd2:  begin legal = plainOk; slot = SL_TTB;  end
        4'd3:  begin legal = plainOk; slot = SL_DOM;  end
        4'd5:  begin legal = plainOk; slot = SL_FSR;  end
        4'd6:  begin legal = plainOk; slot = SL_FAR;  end
        4'd9:  begin legal = plainOk; slot = SL_LOCK; end
        4'd13: begin legal = plainOk; slot = SL_PID;  end
        4'd7, 4'd8, 4'd10: begin legal = 1'b1; slot = SL_NONE; end
        4'd14: begin
          legal = op2Zero;
          case (secIdx)
            4'd0:    slot = SL_DBG0;
            4'd3:    slot = SL_DBG3;
            4'd4:    slot = SL_DBG4;
            4'd8:    slot = SL_DBG8;
            4'd9:    slot = SL_DBG9;
            default: legal = 1'b0;
          endcase
        end
        4'd15: begin legal = (secIdx == 4'd1) && op2Zero; slot = SL_CPACC; end
        default: legal = 1'b0;
      endcase
    end
  end

  assign strb.valid  = cmdValid;
  assign strb.accept = cmdValid && legal;
  assign strb.write  = cmdWrite;
  assign strb.slot   = slot;
endmodule

// File: rtl/sysctl_dpath.sv
module sysctl_dpath
  import sysctl_pkg::*;
#(
  parameter logic [DW-1:0] ID_VALUE = 32'h69052000
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [DW-1:0] wrData,
  output logic          rspValid,
  output logic          rspRefused,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] slotQ [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam slot_e         S = slot_e'(i);
    localparam logic [DW-1:0] M = slotMask(S);
    localparam logic [DW-1:0] F = slotForce(S);
    localparam logic [DW-1:0] R = slotReset(S, ID_VALUE);
    if (M == '0) begin : g_const
      assign slotQ[i] = R;
    end else begin : g_store
      logic [DW-1:0] q;
      logic          hit;
      assign hit = strb.accept && strb.write && (strb.slot == S);
      always_ff @(posedge clk) begin
        if (!rstN)    q <= R;
        else if (hit) q <= (wrData & M) | F;
      end
      assign slotQ[i] = q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspRefused <= 1'b0;
      rdData     <= '0;
    end else begin
      rspValid   <= strb.valid;
      rspRefused <= strb.valid && !strb.accept;
      rdData     <= (strb.accept && !strb.write) ? slotQ[strb.slot] : '0;
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h69052000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdWrite,
  input  logic        userMode,
  input  logic [3:0]  primIdx,
  input  logic [3:0]  secIdx,
  input  logic [2:0]  op1,
  input  logic [2:0]  op2,
  input  logic [31:0] wrData,
  output logic        rspValid,
  output logic        rspRefused,
  output logic [31:0] rdData
);
  strobe_t strb;

  sysctl_ctrl u_ctrl (
    .cmdValid(cmdValid), .cmdWrite(cmdWrite), .userMode(userMode),
    .primIdx(primIdx), .secIdx(secIdx), .op1(op1), .op2(op2), .strb(strb)
  );

  sysctl_dpath #(.ID_VALUE(ID_VALUE)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rspValid(rspValid), .rspRefused(rspRefused), .rdData(rdData)
  );
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter logic [31:0] ID_VALUE = 32'h69052000
) (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        cmdWrite,
  input logic        userMode,
  input logic [3:0]  primIdx,
  input logic [3:0]  secIdx,
  input logic [2:0]  op1,
  input logic [2:0]  op2,
  input logic        rspValid,
  input logic        rspRefused,
  input logic [31:0] rdData
);
  logic privRead;
  assign privRead = cmdValid && !cmdWrite && !userMode && (op1 == 3'd0);

  p_user_refused_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && userMode |=> rspValid && rspRefused);
  p_op1_refused_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (op1 != 3'd0) |=> rspRefused);
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> rspValid);
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !rspValid);
  p_refused_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspRefused |-> rspValid && (rdData == 32'd0));
  // R3 and R9: identity word never changes
  p_id_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    privRead && primIdx == 4'd0 && secIdx == 4'd0 && op2 == 3'd0
    |=> !rspRefused && rdData == ID_VALUE);
  p_ctype_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    privRead && primIdx == 4'd0 && secIdx == 4'd0 && op2 != 3'd0
    |=> !rspRefused && rdData == 32'h0B1AA1AA);
  p_ctrl_forced_r4: assert property (@(posedge clk) disable iff (!rstN)
    privRead && primIdx == 4'd1 && secIdx == 4'd0 && op2 == 3'd0
    |=> rdData[31:14] == 18'd0 && !rdData[10] && rdData[6:3] == 4'hF);
  p_dbg_op2_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && primIdx == 4'd14 && op2 != 3'd0 |=> rspRefused);
  p_cpacc_sec_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && primIdx == 4'd15 && secIdx != 4'd1 |=> rspRefused);
  p_hole_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (primIdx == 4'd4 || primIdx == 4'd11 || primIdx == 4'd12) |=> rspRefused);
  p_nostate_r10: assert property (@(posedge clk) disable iff (!rstN)
    privRead && (primIdx == 4'd7 || primIdx == 4'd8 || primIdx == 4'd10)
    |=> !rspRefused && rdData == 32'd0);
endmodule

bind sysctl_regfile sysctl_regfile_chk #(.ID_VALUE(ID_VALUE)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
  .userMode(userMode), .primIdx(primIdx), .secIdx(secIdx), .op1(op1),
  .op2(op2), .rspValid(rspValid), .rspRefused(rspRefused), .rdData(rdData)
);

// File: tb/sysctl_regfile_test.sv
`timescale 1ns/1ps
module sysctl_regfile_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdWrite = 1'b0, userMode = 1'b0;
  logic [3:0]  primIdx = '0, secIdx = '0;
  logic [2:0]  op1 = '0, op2 = '0;
  logic [31:0] wrData = '0;
  logic        rspValid, rspRefused;
  logic [31:0] rdData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  localparam logic [31:0] ID = 32'h69052000;
  localparam logic [31:0] CT = 32'h0B1AA1AA;
  localparam logic [31:0] F1 = 32'hFFFFFFFF;

  always #4 clk = ~clk;

  sysctl_regfile uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .userMode(userMode), .primIdx(primIdx), .secIdx(secIdx), .op1(op1),
    .op2(op2), .wrData(wrData), .rspValid(rspValid), .rspRefused(rspRefused),
    .rdData(rdData)
  );

  typedef struct packed {
    logic        wr;
    logic        usr;
    logic [3:0]  p;
    logic [3:0]  s;
    logic [2:0]  o1;
    logic [2:0]  o2;
    logic [31:0] d;
    logic        expRef;
    logic [31:0] expRd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 63;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,4'd0,4'd0,3'd0,3'd0,32'h0,1'b0,ID,8'd3},            // R3
    '{1'b0,1'b0,4'd1,4'd0,3'd0,3'd0,32'h0,1'b0,32'h78,8'd3},        // R3
    '{1'b0,1'b0,4'd0,4'd0,3'd0,3'd1,32'h0,1'b0,CT,8'd3},            // R3
    '{1'b0,1'b0,4'd1,4'd0,3'd0,3'd3,32'h0,1'b0,32'h0,8'd3},         // R3
    '{1'b1,1'b0,4'd1,4'd0,3'd0,3'd0,F1,1'b0,32'h0,8'd4},            // R4
    '{1'b0,1'b0,4'd1,4'd0,3'd0,3'd0,32'h0,1'b0,32'h3BFF,8'd4},      // R4
    '{1'b1,1'b0,4'd1,4'd0,3'd0,3'd0,32'h0,1'b0,32'h0,8'd4},         // R4
    '{1'b0,1'b0,4'd1,4'd0,3'd0,3'd0,32'h0,1'b0,32'h78,8'd4},        // R4
    '{1'b1,1'b0,4'd1,4'd0,3'd0,3'd2,F1,1'b0,32'h0,8'd5},            // R5
    '{1'b0,1'b0,4'd1,4'd0,3'd0,3'd5,32'h0,1'b0,32'h33,8'd5},        // R5
    '{1'b0,1'b0,4'd1,4'd0,3'd0,3'd0,32'h0,1'b0,32'h78,8'd5},        // R5
    '{1'b1,1'b0,4'd2,4'd0,3'd0,3'd0,F1,1'b0,32'h0,8'd6},            // R6
    '{1'b0,1'b0,4'd2,4'd0,3'd0,3'd0,32'h0,1'b0,32'hFFFFC000,8'd6},  // R6
    '{1'b1,1'b0,4'd5,4'd0,3'd0,3'd0,F1,1'b0,32'h0,8'd6},            // R6
    '{1'b0,1'b0,4'd5,4'd0,3'd0,3'd0,32'h0,1'b0,32'h6FF,8'd6},       // R6
    '{1'b1,1'b0,4'd9,4'd0,3'd0,3'd0,F1,1'b0,32'h0,8'd6},            // R6
    '{1'b0,1'b0,4'd9,4'd0,3'd0,3'd0,32'h0,1'b0,32'h1,8'd6},         // R6
    '{1'b1,1'b0,4'd13,4'd0,3'd0,3'd0,F1,1'b0,32'h0,8'd6},           // R6
    '{1'b0,1'b0,4'd13,4'd0,3'd0,3'd0,32'h0,1'b0,32'hFE000000,8'd6}, // R6
    '{1'b1,1'b0,4'd15,4'd1,3'd0,3'd0,F1,1'b0,32'h0,8'd6},           // R6
    '{1'b0,1'b0,4'd15,4'd1,3'd0,3'd0,32'h0,1'b0,32'h3FFF,8'd6},     // R6
    '{1'b1,1'b0,4'd3,4'd0,3'd0,3'd0,32'hA5A5A5A5,1'b0,32'h0,8'd6},  // R6
    '{1'b0,1'b0,4'd3,4'd0,3'd0,3'd0,32'h0,1'b0,32'hA5A5A5A5,8'd6},  // R6
    '{1'b1,1'b0,4'd6,4'd0,3'd0,3'd0,32'h12345678,1'b0,32'h0,8'd6},  // R6
    '{1'b0,1'b0,4'd6,4'd0,3'd0,3'd0,32'h0,1'b0,32'h12345678,8'd6},  // R6
    '{1'b0,1'b1,4'd1,4'd0,3'd0,3'd0,32'h0,1'b1,32'h0,8'd1},         // R1
    '{1'b1,1'b1,4'd3,4'd0,3'd0,3'd0,32'h0,1'b1,32'h0,8'd1},         // R1
    '{1'b0,1'b0,4'd3,4'd0,3'd0,3'd0,32'h0,1'b0,32'hA5A5A5A5,8'd1},  // R1
    '{1'b0,1'b0,4'd0,4'd0,3'd1,3'd0,32'h0,1'b1,32'h0,8'd1},         // R1
    '{1'b1,1'b0,4'd6,4'd0,3'd7,3'd0,32'h0,1'b1,32'h0,8'd1},         // R1
    '{1'b0,1'b0,4'd6,4'd0,3'd0,3'd0,32'h0,1'b0,32'h12345678,8'd1},  // R1
    '{1'b0,1'b0,4'd15,4'd0,3'd0,3'd0,32'h0,1'b1,32'h0,8'd8},        // R8
    '{1'b0,1'b0,4'd2,4'd0,3'd0,3'd1,32'h0,1'b1,32'h0,8'd8},         // R8
    '{1'b0,1'b0,4'd2,4'd1,3'd0,3'd0,32'h0,1'b1,32'h0,8'd8},         // R8
    '{1'b0,1'b0,4'd4,4'd0,3'd0,3'd0,32'h0,1'b1,32'h0,8'd8},         // R8
    '{1'b0,1'b0,4'd11,4'd0,3'd0,3'd0,32'h0,1'b1,32'h0,8'd8},        // R8
    '{1'b0,1'b0,4'd0,4'd2,3'd0,3'd0,32'h0,1'b1,32'h0,8'd8},         // R8
    '{1'b1,1'b0,4'd12,4'd0,3'd0,3'd0,F1,1'b1,32'h0,8'd8},           // R8
    '{1'b1,1'b0,4'd14,4'd0,3'd0,3'd0,32'h11111111,1'b0,32'h0,8'd7}, // R7
    '{1'b1,1'b0,4'd14,4'd3,3'd0,3'd0,32'h22222222,1'b0,32'h0,8'd7}, // R7
    '{1'b1,1'b0,4'd14,4'd4,3'd0,3'd0,32'h33333333,1'b0,32'h0,8'd7}, // R7
    '{1'b1,1'b0,4'd14,4'd8,3'd0,3'd0,32'h44444444,1'b0,32'h0,8'd7}, // R7
    '{1'b1,1'b0,4'd14,4'd9,3'd0,3'd0,32'h55555555,1'b0,32'h0,8'd7}, // R7
    '{1'b0,1'b0,4'd14,4'd0,3'd0,3'd0,32'h0,1'b0,32'h11111111,8'd7}, // R7
    '{1'b0,1'b0,4'd14,4'd3,3'd0,3'd0,32'h0,1'b0,32'h22222222,8'd7}, // R7
    '{1'b0,1'b0,4'd14,4'd4,3'd0,3'd0,32'h0,1'b0,32'h33333333,8'd7}, // R7
    '{1'b0,1'b0,4'd14,4'd8,3'd0,3'd0,32'h0,1'b0,32'h44444444,8'd7}, // R7
    '{1'b0,1'b0,4'd14,4'd9,3'd0,3'd0,32'h0,1'b0,32'h55555555,8'd7}, // R7
    '{1'b0,1'b0,4'd14,4'd5,3'd0,3'd0,32'h0,1'b1,32'h0,8'd7},        // R7
    '{1'b1,1'b0,4'd14,4'd3,3'd0,3'd1,32'h0,1'b1,32'h0,8'd7},        // R7
    '{1'b0,1'b0,4'd14,4'd3,3'd0,3'd0,32'h0,1'b0,32'h22222222,8'd7}, // R7
    '{1'b1,1'b0,4'd0,4'd0,3'd0,3'd0,32'h0,1'b0,32'h0,8'd9},         // R9
    '{1'b0,1'b0,4'd0,4'd0,3'd0,3'd0,32'h0,1'b0,ID,8'd9},            // R9
    '{1'b1,1'b0,4'd0,4'd0,3'd0,3'd1,F1,1'b0,32'h0,8'd9},            // R9
    '{1'b0,1'b0,4'd0,4'd0,3'd0,3'd1,32'h0,1'b0,CT,8'd9},            // R9
    '{1'b1,1'b0,4'd7,4'd5,3'd0,3'd4,F1,1'b0,32'h0,8'd10},           // R10
    '{1'b0,1'b0,4'd7,4'd9,3'd0,3'd2,32'h0,1'b0,32'h0,8'd10},        // R10
    '{1'b1,1'b0,4'd8,4'd7,3'd0,3'd0,F1,1'b0,32'h0,8'd10},           // R10
    '{1'b0,1'b0,4'd8,4'd7,3'd0,3'd0,32'h0,1'b0,32'h0,8'd10},        // R10
    '{1'b1,1'b0,4'd10,4'd1,3'd0,3'd1,F1,1'b0,32'h0,8'd10},          // R10
    '{1'b0,1'b0,4'd10,4'd1,3'd0,3'd1,32'h0,1'b0,32'h0,8'd10},       // R10
    '{1'b1,1'b0,4'd13,4'd1,3'd0,3'd0,32'h0,1'b1,32'h0,8'd8},        // R8
    '{1'b0,1'b0,4'd13,4'd0,3'd0,3'd0,32'h0,1'b0,32'hFE000000,8'd8}  // R8
  };

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic usr, input logic [3:0] p,
                        input logic [3:0] s, input logic [2:0] o1,
                        input logic [2:0] o2, input logic [31:0] d,
                        output logic gv, output logic gr, output logic [31:0] gd);
    cmdValid = 1'b1; cmdWrite = wr; userMode = usr;
    primIdx = p; secIdx = s; op1 = o1; op2 = o2; wrData = d;
    @(posedge clk);
    @(negedge clk);
    gv = rspValid; gr = rspRefused; gd = rdData;
    cmdValid = 1'b0; cmdWrite = 1'b0; userMode = 1'b0;
  endtask

  task automatic readExpect(input logic [3:0] p, input logic [3:0] s,
                            input logic [2:0] o2, input logic [31:0] exp,
                            input string req);
    logic gv, gr;
    logic [31:0] gd;
    access(1'b0, 1'b0, p, s, 3'd0, o2, 32'h0, gv, gr, gd);
    check(gv && !gr && gd == exp, req, gd, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic gv, gr;
    logic [31:0] gd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 / R2: quiet outputs after reset
    check(!rspValid && !rspRefused && rdData == 32'h0, "R11 reset outputs",
          {30'd0, rspValid, rspRefused}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].usr, VECS[i].p, VECS[i].s, VECS[i].o1,
             VECS[i].o2, VECS[i].d, gv, gr, gd);
      testsRun++;
      if (!gv || gr !== VECS[i].expRef || gd !== VECS[i].expRd) begin
        testsFailed++;
        $display("FAIL R%0d vector %0d: got v=%b ref=%b rd=%h expected v=1 ref=%b rd=%h",
                 VECS[i].req, i, gv, gr, gd, VECS[i].expRef, VECS[i].expRd);
      end
    end

    // R2: idle cycle gives no response
    @(negedge clk);
    check(!rspValid, "R2 idle", {31'd0, rspValid}, 32'h0);

    // R11: reset mid-run restores defaults
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(!rspValid && rdData == 32'h0, "R11 reset in run", rdData, 32'h0);
    rstN = 1'b1;
    readExpect(4'd3, 4'd0, 3'd0, 32'h0, "R11 domain cleared");
    readExpect(4'd1, 4'd0, 3'd0, 32'h78, "R11 control default");
    readExpect(4'd1, 4'd0, 3'd2, 32'h0, "R11 aux cleared");
    readExpect(4'd14, 4'd3, 3'd0, 32'h0, "R11 debug cleared");
    readExpect(4'd15, 4'd1, 3'd0, 32'h0, "R11 access word cleared");
    readExpect(4'd0, 4'd0, 3'd0, ID, "R11 identity");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule